// File: doc/BRIEF.md
# In-Order Store Writeback Queue

This block holds stores between execution and their arrival in the data cache. Each store is placed at the tail of a circular queue when it executes, with its sequence number, access size, address, data and a kind code. When the pipeline commits up to a given sequence number, the block marks the matching stores as ready. It then sends them to the cache one per cycle in program order, through a request port with a same-cycle accept signal. A slot is freed only once its store has been reported complete. Completions may arrive in any order, and the oldest slot then retires together with the run of completed slots behind it. A squash removes not-yet-committed stores from the young end of the queue.

Three pointers drive the queue. The head retires finished stores, the writeback pointer walks ahead of it sending ready stores, and the tail takes new stores. A two-state machine governs the writeback pointer. In ISSUE it attempts one step per cycle. A refused request moves it to STALL (transition ISSUE->STALL). A retry pulse from the cache returns it to ISSUE (transition STALL->ISSUE). The block also reports a free-entry count that combines its own free slots with a free-slot count supplied by the load side.

Top module: `sq_writeback`

## Requirements
- R1: After reset the queue is empty. `free_cnt_o` equals DEPTH (given enough load-side room), `alloc_ready_o` is 1 and `wr_req_o` is 0.
- R2: The queue has DEPTH+1 slots, one always left unused. Once DEPTH stores are held, `alloc_ready_o` is 0. An allocation offered while full leaves the tail index `alloc_idx_o` unchanged.
- R3: `free_cnt_o` is min(`ld_free_i`, DEPTH+1 minus stores held) minus 1, and is 0 when that minimum is 0.
- R4: A commit walks from the oldest store toward the youngest and marks each unmarked store as ready. The walk stops at the first unmarked store whose sequence number exceeds the commit value. No write request is made for a store that has not been marked.
- R5: Ready stores are requested strictly in queue order, at most one per cycle. `wr_idx_o`, `wr_addr_o`, `wr_data_o` and `wr_size_o` show the slot being requested. The writeback pointer moves on only in a cycle where `wr_accept_i` is 1.
- R6: A request seen with `wr_accept_i` at 0 moves the state machine to STALL. No request is made in STALL. A `wr_retry_i` pulse returns it to ISSUE, and the same slot is then requested again.
- R7: A store whose size is 0 is completed by the block itself without a request, and its slot can retire with no completion input.
- R8: A store of kind 1 (prefetch) takes a writeback step without a request. The pointer moves past it, but its slot retires only after a completion names its index.
- R9: A completion marks its slot done. The head retires only when its own slot is done, and it then frees every consecutive done slot behind it in the same cycle.
- R10: A squash walks back from the youngest store, removing stores whose sequence number exceeds the squash value. It stops at the first store already marked ready.
- R11: A store of kind 2 (conditional) is marked ready when it is allocated, without waiting for a commit.
- R12: An allocation offered in the same cycle as a squash is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Offer an executed store |
| alloc_seq_i | input | SEQ_W | Sequence number of the store |
| alloc_kind_i | input | 2 | 0 plain, 1 prefetch, 2 conditional |
| alloc_size_i | input | SIZE_W | Access size in bytes, 0 for no data |
| alloc_addr_i | input | ADDR_W | Store address |
| alloc_data_i | input | DATA_W | Store data |
| alloc_ready_o | output | 1 | Queue can take a store this cycle |
| alloc_idx_o | output | IW | Slot that the next store will occupy |
| commit_valid_i | input | 1 | Commit up to a sequence number |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash younger stores |
| squash_seq_i | input | SEQ_W | Stores above this number are removed |
| wr_req_o | output | 1 | Cache write request |
| wr_idx_o | output | IW | Slot of the requested store |
| wr_addr_o | output | ADDR_W | Request address |
| wr_data_o | output | DATA_W | Request data |
| wr_size_o | output | SIZE_W | Request size |
| wr_accept_i | input | 1 | Cache takes the request this cycle |
| wr_retry_i | input | 1 | Cache can take requests again |
| cpl_valid_i | input | 1 | A sent store has completed |
| cpl_idx_i | input | IW | Slot of the completed store |
| ld_free_i | input | LDF_W | Free slots on the load side, spare included |
| free_cnt_o | output | IW | Entries that can still be accepted |

## Verification
The hardest state to reach is the one where the writeback pointer, the head and the squash walk all run into each other. This needs a committed conditional store sitting between uncommitted ones, so that the squash stops at it. It also needs a prefetch or zero-size slot in front of a normal store, so that the pointer and the head separate. The stimulus builds these by filling the queue to capacity with a chosen mix of kinds. It then completes slots out of order, and squashes while a younger allocation is offered. It holds `wr_accept_i` low across several cycles before a retry pulse, to exercise the stalled state.

// File: rtl/sqwb_pkg.sv
package sqwb_pkg;

    typedef enum logic [1:0] {
        KIND_PLAIN    = 2'd0,
        KIND_PREFETCH = 2'd1,
        KIND_COND     = 2'd2
    } st_kind_e;

    typedef enum logic {
        WB_ISSUE = 1'b0,
        WB_STALL = 1'b1
    } wb_state_e;

endpackage

// File: rtl/sqwb_commit_scan.sv
module sqwb_commit_scan #(
    parameter int NSLOT = 5,
    parameter int IW    = 3,
    parameter int SEQ_W = 8
) (
    input  logic [IW-1:0]    head_i,
    input  logic [IW-1:0]    count_i,
    input  logic             commit_valid_i,
    input  logic [SEQ_W-1:0] commit_seq_i,
    input  logic [SEQ_W-1:0] seq_i [NSLOT],
    input  logic [NSLOT-1:0] ready_i,
    output logic [NSLOT-1:0] mark_o,
    output logic [IW:0]      mark_cnt_o
);

    logic          walking;
    logic [IW-1:0] slot;

    // Oldest to youngest; stop at the first unmarked store past the commit point.
    always_comb begin
        mark_o     = '0;
        mark_cnt_o = '0;
        walking    = commit_valid_i;
        slot       = '0;
        for (int k = 0; k < NSLOT; k++) begin
            slot = IW'((int'(head_i) + k) % NSLOT);
            if (walking && (k < int'(count_i)) && !ready_i[slot]) begin
                if (seq_i[slot] > commit_seq_i) begin
                    walking = 1'b0;
                end else begin
                    mark_o[slot] = 1'b1;
                    mark_cnt_o   = mark_cnt_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sqwb_squash_scan.sv
module sqwb_squash_scan #(
    parameter int NSLOT = 5,
    parameter int IW    = 3,
    parameter int SEQ_W = 8
) (
    input  logic [IW-1:0]    tail_i,
    input  logic [IW-1:0]    count_i,
    input  logic             squash_valid_i,
    input  logic [SEQ_W-1:0] squash_seq_i,
    input  logic [SEQ_W-1:0] seq_i [NSLOT],
    input  logic [NSLOT-1:0] keep_i,
    output logic [NSLOT-1:0] kill_o,
    output logic [IW-1:0]    kill_cnt_o
);

    logic          walking;
    logic [IW-1:0] slot;

    // Youngest to oldest; a store already marked ready ends the walk.
    always_comb begin
        kill_o     = '0;
        kill_cnt_o = '0;
        walking    = squash_valid_i;
        slot       = '0;
        for (int k = 0; k < NSLOT; k++) begin
            slot = IW'((int'(tail_i) + NSLOT - 1 - k) % NSLOT);
            if (walking && (k < int'(count_i))) begin
                if (keep_i[slot] || !(seq_i[slot] > squash_seq_i)) begin
                    walking = 1'b0;
                end else begin
                    kill_o[slot] = 1'b1;
                    kill_cnt_o   = kill_cnt_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sqwb_wb_fsm.sv
module sqwb_wb_fsm
    import sqwb_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] tail_i,
    input  logic          await_nz_i,
    input  logic          ready_i,
    input  logic          zero_i,
    input  logic          pref_i,
    input  logic          accept_i,
    input  logic          retry_i,
    output logic [IW-1:0] wbp_o,
    output logic          req_o,
    output logic          zero_done_o
);

    wb_state_e     state_q;
    wb_state_e     state_d;
    logic [IW-1:0] wbp_q;
    logic          advance;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WB_ISSUE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d     = state_q;
        req_o       = 1'b0;
        zero_done_o = 1'b0;
        advance     = 1'b0;
        unique case (state_q)
            WB_ISSUE: begin
                if (await_nz_i && (wbp_q != tail_i) && ready_i) begin
                    if (zero_i) begin
                        zero_done_o = 1'b1;
                        advance     = 1'b1;
                    end else if (pref_i) begin
                        advance = 1'b1;
                    end else begin
                        req_o = 1'b1;
                        if (accept_i) begin
                            advance = 1'b1;
                        end else begin
                            state_d = WB_STALL;
                        end
                    end
                end
            end
            WB_STALL: begin
                if (retry_i) begin
                    state_d = WB_ISSUE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbp_q <= '0;
        end else if (advance) begin
            wbp_q <= (int'(wbp_q) == NSLOT - 1) ? '0 : wbp_q + 1'b1;
        end
    end

    assign wbp_o = wbp_q;

    // R6: a refused request is not repeated until a retry arrives.
    p_refuse_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !accept_i && !retry_i) |=> !req_o)
        else $error("refused request repeated without retry");

endmodule

// File: rtl/sq_writeback.sv
module sq_writeback
    import sqwb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 4,
    parameter int LDF_W  = 4,
    localparam int NSLOT = DEPTH + 1,
    localparam int IW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [SEQ_W-1:0]  alloc_seq_i,
    input  logic [1:0]        alloc_kind_i,
    input  logic [SIZE_W-1:0] alloc_size_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [DATA_W-1:0] alloc_data_i,
    output logic              alloc_ready_o,
    output logic [IW-1:0]     alloc_idx_o,
    input  logic              commit_valid_i,
    input  logic [SEQ_W-1:0]  commit_seq_i,
    input  logic              squash_valid_i,
    input  logic [SEQ_W-1:0]  squash_seq_i,
    output logic              wr_req_o,
    output logic [IW-1:0]     wr_idx_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [SIZE_W-1:0] wr_size_o,
    input  logic              wr_accept_i,
    input  logic              wr_retry_i,
    input  logic              cpl_valid_i,
    input  logic [IW-1:0]     cpl_idx_i,
    input  logic [LDF_W-1:0]  ld_free_i,
    output logic [IW-1:0]     free_cnt_o
);

    // Slot storage.
    logic [SEQ_W-1:0]  seq_q  [NSLOT];
    logic [ADDR_W-1:0] addr_q [NSLOT];
    logic [DATA_W-1:0] data_q [NSLOT];
    logic [SIZE_W-1:0] size_q [NSLOT];
    st_kind_e          kind_q [NSLOT];
    logic [NSLOT-1:0]  ready_q;
    logic [NSLOT-1:0]  done_q;

    logic [IW-1:0]     head_q, tail_q, head_d, tail_d;
    logic [IW:0]       await_q, await_d;
    logic [IW-1:0]     count;
    logic              full;
    logic              alloc_ok;
    logic              alloc_cond;
    st_kind_e          alloc_kind;

    logic [NSLOT-1:0]  mark;
    logic [IW:0]       mark_cnt;
    logic [NSLOT-1:0]  kill;
    logic [IW-1:0]     kill_cnt;
    logic [NSLOT-1:0]  keep;

    logic [NSLOT-1:0]  is_zero;
    logic [NSLOT-1:0]  is_pref;
    logic [IW-1:0]     wbp;
    logic              zero_done;
    logic [NSLOT-1:0]  done_set;
    logic [NSLOT-1:0]  done_next;
    logic [NSLOT-1:0]  retire;
    logic [IW-1:0]     retire_cnt;
    logic              retiring;
    logic [IW-1:0]     rslot;
    logic [IW:0]       sq_free;
    logic [LDF_W:0]    lowest;

    // Occupancy and full detection (one slot always left unused).
    assign count         = IW'((int'(tail_q) - int'(head_q) + NSLOT) % NSLOT);
    assign full          = (IW'((int'(tail_q) + 1) % NSLOT) == head_q);
    assign alloc_ok      = alloc_valid_i && !full && !squash_valid_i;
    assign alloc_kind    = st_kind_e'(alloc_kind_i);
    assign alloc_cond    = alloc_ok && (alloc_kind == KIND_COND);
    assign alloc_ready_o = !full;
    assign alloc_idx_o   = tail_q;

    // Per-slot decode for the writeback step.
    for (genvar s = 0; s < NSLOT; s++) begin : g_decode
        assign is_zero[s] = (size_q[s] == '0);
        assign is_pref[s] = (kind_q[s] == KIND_PREFETCH);
    end

    sqwb_commit_scan #(.NSLOT(NSLOT), .IW(IW), .SEQ_W(SEQ_W)) u_commit (
        .head_i        (head_q),
        .count_i       (count),
        .commit_valid_i(commit_valid_i),
        .commit_seq_i  (commit_seq_i),
        .seq_i         (seq_q),
        .ready_i       (ready_q),
        .mark_o        (mark),
        .mark_cnt_o    (mark_cnt)
    );

    assign keep = ready_q | mark;

    sqwb_squash_scan #(.NSLOT(NSLOT), .IW(IW), .SEQ_W(SEQ_W)) u_squash (
        .tail_i        (tail_q),
        .count_i       (count),
        .squash_valid_i(squash_valid_i),
        .squash_seq_i  (squash_seq_i),
        .seq_i         (seq_q),
        .keep_i        (keep),
        .kill_o        (kill),
        .kill_cnt_o    (kill_cnt)
    );

    sqwb_wb_fsm #(.NSLOT(NSLOT), .IW(IW)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tail_i     (tail_q),
        .await_nz_i (await_q != '0),
        .ready_i    (ready_q[wbp]),
        .zero_i     (is_zero[wbp]),
        .pref_i     (is_pref[wbp]),
        .accept_i   (wr_accept_i),
        .retry_i    (wr_retry_i),
        .wbp_o      (wbp),
        .req_o      (wr_req_o),
        .zero_done_o(zero_done)
    );

    assign wr_idx_o  = wbp;
    assign wr_addr_o = addr_q[wbp];
    assign wr_data_o = data_q[wbp];
    assign wr_size_o = size_q[wbp];

    // Completion sources: external index and the zero-size step.
    always_comb begin
        done_set = '0;
        if (cpl_valid_i) begin
            done_set[cpl_idx_i] = 1'b1;
        end
        if (zero_done) begin
            done_set[wbp] = 1'b1;
        end
        done_next = done_q | done_set;
    end

    // Head retires the run of finished slots starting at itself.
    always_comb begin
        retire     = '0;
        retire_cnt = '0;
        retiring   = 1'b1;
        rslot      = '0;
        for (int k = 0; k < NSLOT; k++) begin
            rslot = IW'((int'(head_q) + k) % NSLOT);
            if (retiring && (k < int'(count))) begin
                if (done_next[rslot]) begin
                    retire[rslot] = 1'b1;
                    retire_cnt    = retire_cnt + 1'b1;
                end else begin
                    retiring = 1'b0;
                end
            end
        end
    end

    always_comb begin
        head_d = IW'((int'(head_q) + int'(retire_cnt)) % NSLOT);
        if (squash_valid_i) begin
            tail_d = IW'((int'(tail_q) - int'(kill_cnt) + NSLOT) % NSLOT);
        end else if (alloc_ok) begin
            tail_d = IW'((int'(tail_q) + 1) % NSLOT);
        end else begin
            tail_d = tail_q;
        end
        await_d = await_q + mark_cnt + (IW+1)'(alloc_cond)
                - (IW+1)'(cpl_valid_i) - (IW+1)'(zero_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            await_q <= '0;
            ready_q <= '0;
            done_q  <= '0;
        end else begin
            head_q  <= head_d;
            tail_q  <= tail_d;
            await_q <= await_d;
            for (int s = 0; s < NSLOT; s++) begin
                if (alloc_ok && (int'(tail_q) == s)) begin
                    ready_q[s] <= alloc_cond;
                    done_q[s]  <= 1'b0;
                end else if (retire[s] || kill[s]) begin
                    ready_q[s] <= 1'b0;
                    done_q[s]  <= 1'b0;
                end else begin
                    if (mark[s]) begin
                        ready_q[s] <= 1'b1;
                    end
                    if (done_set[s]) begin
                        done_q[s] <= 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            if (alloc_ok && (int'(tail_q) == s)) begin
                seq_q[s]  <= alloc_seq_i;
                addr_q[s] <= alloc_addr_i;
                data_q[s] <= alloc_data_i;
                size_q[s] <= alloc_size_i;
                kind_q[s] <= alloc_kind;
            end
        end
    end

    // Free entries: the tighter of both sides, less the unused slot.
    always_comb begin
        sq_free = (IW+1)'(NSLOT - int'(count));
        if (int'(ld_free_i) < int'(sq_free)) begin
            lowest = (LDF_W+1)'(ld_free_i);
        end else begin
            lowest = (LDF_W+1)'(sq_free);
        end
        free_cnt_o = (lowest == '0) ? '0 : IW'(lowest - 1'b1);
    end

    // R2: a refused allocation leaves the tail where it was.
    p_tail_hold_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !alloc_ready_o && !squash_valid_i) |=> $stable(alloc_idx_o))
        else $error("tail moved on a full queue");

    // R6: a refused request keeps the writeback pointer on its slot.
    p_refuse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_accept_i) |=> $stable(wr_idx_o))
        else $error("writeback pointer moved on refusal");

    // R5: the writeback pointer never runs ahead of the tail or behind the head.
    p_wbp_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(wbp) - int'(head_q) + NSLOT) % NSLOT) <= int'(count))
        else $error("writeback pointer outside occupied range");

    // R4: stores awaiting writeback never outnumber the stores held.
    p_await_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(await_q) <= int'(count))
        else $error("awaiting count exceeds occupancy");

endmodule

// File: tb/sq_writeback_tb_top.sv
`timescale 1ns/1ps
module sq_writeback_tb_top;

    localparam int DEPTH = 4;
    localparam int IW    = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid_i;
    logic [7:0]  alloc_seq_i;
    logic [1:0]  alloc_kind_i;
    logic [3:0]  alloc_size_i;
    logic [15:0] alloc_addr_i;
    logic [31:0] alloc_data_i;
    logic        alloc_ready_o;
    logic [IW-1:0] alloc_idx_o;
    logic        commit_valid_i;
    logic [7:0]  commit_seq_i;
    logic        squash_valid_i;
    logic [7:0]  squash_seq_i;
    logic        wr_req_o;
    logic [IW-1:0] wr_idx_o;
    logic [15:0] wr_addr_o;
    logic [31:0] wr_data_o;
    logic [3:0]  wr_size_o;
    logic        wr_accept_i;
    logic        wr_retry_i;
    logic        cpl_valid_i;
    logic [IW-1:0] cpl_idx_i;
    logic [3:0]  ld_free_i;
    logic [IW-1:0] free_cnt_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // {ld_free, expected free count} with an empty queue (R3).
    localparam logic [6:0] FREE_VEC [6] = '{
        {4'd0, 3'd0}, {4'd1, 3'd0}, {4'd2, 3'd1},
        {4'd3, 3'd2}, {4'd5, 3'd4}, {4'd9, 3'd4}
    };

    always #2.5 clk = ~clk;

    sq_writeback #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_seq_i(alloc_seq_i),
        .alloc_kind_i(alloc_kind_i), .alloc_size_i(alloc_size_i),
        .alloc_addr_i(alloc_addr_i), .alloc_data_i(alloc_data_i),
        .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
        .commit_valid_i(commit_valid_i), .commit_seq_i(commit_seq_i),
        .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
        .wr_req_o(wr_req_o), .wr_idx_o(wr_idx_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_size_o(wr_size_o),
        .wr_accept_i(wr_accept_i), .wr_retry_i(wr_retry_i),
        .cpl_valid_i(cpl_valid_i), .cpl_idx_i(cpl_idx_i),
        .ld_free_i(ld_free_i), .free_cnt_o(free_cnt_o)
    );

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [7:0] seq, input logic [1:0] kind,
                         input logic [3:0] size, input logic [15:0] addr,
                         input logic [31:0] data);
        alloc_valid_i = 1'b1; alloc_seq_i = seq; alloc_kind_i = kind;
        alloc_size_i = size; alloc_addr_i = addr; alloc_data_i = data;
        step();
        alloc_valid_i = 1'b0;
    endtask

    task automatic commit(input logic [7:0] seq);
        commit_valid_i = 1'b1; commit_seq_i = seq;
        step();
        commit_valid_i = 1'b0;
    endtask

    task automatic complete(input logic [IW-1:0] idx);
        cpl_valid_i = 1'b1; cpl_idx_i = idx;
        step();
        cpl_valid_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; alloc_valid_i = 0; alloc_seq_i = 0; alloc_kind_i = 0;
        alloc_size_i = 0; alloc_addr_i = 0; alloc_data_i = 0;
        commit_valid_i = 0; commit_seq_i = 0; squash_valid_i = 0; squash_seq_i = 0;
        wr_accept_i = 1; wr_retry_i = 0; cpl_valid_i = 0; cpl_idx_i = 0;
        ld_free_i = 4'd9;
        step(); step(); step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1 free", free_cnt_o, 4);
        chk("R1 alloc_ready", alloc_ready_o, 1);
        chk("R1 wr_req", wr_req_o, 0);

        // R3: table of load-side room against expected free count
        foreach (FREE_VEC[i]) begin
            ld_free_i = FREE_VEC[i][6:3];
            #1;
            chk("R3 free table", free_cnt_o, FREE_VEC[i][2:0]);
        end
        ld_free_i = 4'd9;

        // Fill, commit part, out-of-order completion
        alloc(8'd10, 2'd0, 4'd4, 16'h100, 32'hA0);
        alloc(8'd11, 2'd0, 4'd4, 16'h101, 32'hA1);
        chk("R3 free two held", free_cnt_o, 2);
        ld_free_i = 4'd2;
        #1;
        chk("R3 load side tighter", free_cnt_o, 1);
        ld_free_i = 4'd9;
        alloc(8'd12, 2'd0, 4'd4, 16'h102, 32'hA2);
        alloc(8'd13, 2'd0, 4'd4, 16'h103, 32'hA3);
        chk("R2 full alloc_ready", alloc_ready_o, 0);
        chk("R3 free full", free_cnt_o, 0);
        alloc(8'd14, 2'd0, 4'd4, 16'h104, 32'hA4);
        chk("R2 full tail held", alloc_idx_o, 4);
        chk("R4 no request before commit", wr_req_o, 0);
        commit(8'd11);
        chk("R5 first req", wr_req_o, 1);
        chk("R5 first idx", wr_idx_o, 0);
        chk("R5 first addr", wr_addr_o, 16'h100);
        chk("R5 first data", wr_data_o, 32'hA0);
        step();
        chk("R5 second idx", wr_idx_o, 1);
        chk("R5 second size", wr_size_o, 4);
        step();
        chk("R4 stop at uncommitted", wr_req_o, 0);
        complete(3'd1);
        chk("R9 head not done holds", free_cnt_o, 0);
        complete(3'd0);
        chk("R9 burst retire", free_cnt_o, 2);
        commit(8'd13);
        chk("R5 third idx", wr_idx_o, 2);
        step();
        chk("R5 fourth data", wr_data_o, 32'hA3);
        step();
        chk("R5 idle at tail", wr_req_o, 0);
        complete(3'd3);
        chk("R9 young done waits", free_cnt_o, 2);
        complete(3'd2);
        chk("R9 drained", free_cnt_o, 4);

        // R6: refusal and retry
        wr_accept_i = 1'b0;
        alloc(8'd20, 2'd0, 4'd4, 16'h200, 32'hB0);
        alloc(8'd21, 2'd0, 4'd4, 16'h201, 32'hB1);
        commit(8'd21);
        chk("R5 req before refusal", wr_idx_o, 4);
        step();
        chk("R6 stalled no req", wr_req_o, 0);
        step();
        chk("R6 still stalled", wr_req_o, 0);
        wr_retry_i = 1'b1;
        step();
        wr_retry_i = 1'b0;
        chk("R6 retry req", wr_req_o, 1);
        chk("R6 same slot", wr_idx_o, 4);
        wr_accept_i = 1'b1;
        step();
        chk("R6 next after accept", wr_idx_o, 0);
        step();
        complete(3'd4);
        complete(3'd0);
        chk("R6 drained", free_cnt_o, 4);

        // R7 zero size, R8 prefetch
        alloc(8'd30, 2'd0, 4'd0, 16'h300, 32'hC0);
        alloc(8'd31, 2'd1, 4'd4, 16'h310, 32'hC1);
        alloc(8'd32, 2'd0, 4'd4, 16'h320, 32'hC2);
        chk("R3 three held", free_cnt_o, 1);
        commit(8'd32);
        chk("R7 no request for zero size", wr_req_o, 0);
        step();
        chk("R7 zero size retired", free_cnt_o, 2);
        chk("R8 no request for prefetch", wr_req_o, 0);
        step();
        chk("R8 pointer past prefetch", wr_idx_o, 3);
        chk("R8 next addr", wr_addr_o, 16'h320);
        step();
        chk("R8 idle", wr_req_o, 0);
        complete(3'd3);
        chk("R8 prefetch slot held", free_cnt_o, 2);
        complete(3'd2);
        chk("R8 prefetch completion frees", free_cnt_o, 4);

        // R11 conditional, R10 squash, R12 alloc during squash
        alloc(8'd40, 2'd2, 4'd4, 16'h400, 32'hD0);
        chk("R11 conditional ready at alloc", wr_req_o, 1);
        chk("R11 conditional idx", wr_idx_o, 4);
        step();
        complete(3'd4);
        alloc(8'd41, 2'd0, 4'd4, 16'h410, 32'hD1);
        alloc(8'd42, 2'd2, 4'd4, 16'h420, 32'hD2);
        alloc(8'd43, 2'd0, 4'd4, 16'h430, 32'hD3);
        alloc(8'd44, 2'd0, 4'd4, 16'h440, 32'hD4);
        chk("R4 older unmarked blocks", wr_req_o, 0);
        squash_valid_i = 1'b1; squash_seq_i = 8'd40;
        step();
        squash_valid_i = 1'b0;
        chk("R10 tail after squash", alloc_idx_o, 2);
        chk("R10 free after squash", free_cnt_o, 2);
        squash_valid_i = 1'b1; squash_seq_i = 8'd60;
        alloc(8'd61, 2'd0, 4'd4, 16'h610, 32'hE1);
        squash_valid_i = 1'b0;
        chk("R12 alloc dropped idx", alloc_idx_o, 2);
        chk("R12 alloc dropped free", free_cnt_o, 2);
        commit(8'd41);
        chk("R10 survivor requested", wr_idx_o, 0);
        step();
        chk("R10 conditional kept", wr_data_o, 32'hD2);
        step();
        chk("R10 nothing beyond", wr_req_o, 0);
        complete(3'd0);
        complete(3'd1);
        chk("R10 drained", free_cnt_o, 4);

        finished = 1'b1;
        report();
    end

endmodule